// File: doc/BRIEF.md
# Keyed Register Unlock Sequencer

This block stands guard over one protected control register. Before the protected register takes a write, software has to put an exact ordered series of key values into a companion lock register. The lock register always reports how far the sequence has got as a two-bit status. Software reads that status after each key write and compares it with the value it expects before it writes the next key. When the status shows 3, one write to the protected register is accepted. The block latches the value, raises a one-cycle write-enable pulse for whatever the register controls, and locks itself again.

The number of keys (two or three) and the key values are parameters, so one design covers both variants. With two keys the status goes 0, 1, 3. With three keys it goes 0, 1, 2, 3. A wrong key, or a lock write once the sequence is complete, returns the status to 0. A protected write while the block is locked is dropped, and a sticky violation flag records it. Both registers sit on a simple write port and a combinational read port.

Top module: `keyed_unlock_seq`

## Requirements
- R1: After reset the lock status is 0, the protected value equals the `RESET_VAL` parameter, the write-enable pulse is low and the violation flag is clear.
- R2: With two keys, writing key 0 to the lock offset sets the status to 1, and then writing key 1 sets it to 3 (unlocked).
- R3: With three keys, the status steps to 1, then 2, then 3 as key 0, key 1 and key 2 are written in that order.
- R4: A lock write whose full data word differs from the next expected key returns the status to 0. This covers a repeated key, a key out of order, and a key with nonzero bits above the key width.
- R5: A write to the protected offset while the status is 3 loads the write data into the protected value, drives the write-enable high for exactly the following cycle, and returns the status to 0.
- R6: A write to the protected offset while the status is not 3 leaves the protected value unchanged, gives no write-enable pulse, leaves the status as it was, and sets the violation flag. The flag stays set until reset, including through later accepted writes.
- R7: A read of the lock offset returns the status in bits [1:0] with all higher bits zero. A read of the protected offset returns the protected value. A read of any other offset returns zero.
- R8: A lock write of any value while the status is 3 returns the status to 0, so a following protected write is refused.
- R9: A write to an offset that is neither the lock nor the protected offset changes neither the status nor the protected value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| lock_status | output | 2 | Unlock progress; 3 means unlocked |
| prot_we | output | 1 | One-cycle pulse after an accepted protected write |
| prot_value | output | DATA_W | Latched protected register value |
| viol | output | 1 | Sticky flag for refused protected writes |

## Verification
The key sequence is driven in its correct order on a two-key and a three-key instance. It is also driven in broken orders: a repeated first key, the second key first, the last key skipped, and a key with stray high bits. Each broken order shows that progress depends on the full value and on the position in the sequence, not just on seeing a key. Protected writes are tried while locked, while partly unlocked, while fully unlocked, and after a re-lock. This separates the one-shot acceptance and the sticky violation from a design that stays open or clears the flag. Writes and reads at an unmapped offset show that decoding cannot leak into either register.

// File: rtl/keyed_unlock_pkg.sv
package keyed_unlock_pkg;
   localparam int MAX_KEYS = 3;
   typedef logic [1:0] lock_st_t;
   localparam lock_st_t ST_LOCKED = 2'd0;
   localparam lock_st_t ST_OPEN   = 2'd3;
endpackage

// File: rtl/unlock_key_match.sv
module unlock_key_match #(
   parameter int DATA_W   = 32,
   parameter int KEY_W    = 16,
   parameter int NUM_KEYS = 2,
   parameter logic [keyed_unlock_pkg::MAX_KEYS*KEY_W-1:0] KEYS = '0,
   localparam int STG_W   = $clog2(NUM_KEYS + 1)
) (
   input  logic [STG_W-1:0]  stage,
   input  logic [DATA_W-1:0] wr_data,
   output logic              key_hit
);
   logic [NUM_KEYS-1:0] hit_vec;
   logic [NUM_KEYS-1:0] sel_vec;

   // one comparator per key position; the stage selects which one counts
   for (genvar i = 0; i < NUM_KEYS; i++) begin : g_cmp
      assign hit_vec[i] = (wr_data == DATA_W'(KEYS[i*KEY_W +: KEY_W]));
      assign sel_vec[i] = (stage == STG_W'(i));
   end

   assign key_hit = |(hit_vec & sel_vec);
endmodule

// File: rtl/unlock_stage_ctrl.sv
module unlock_stage_ctrl
   import keyed_unlock_pkg::*;
#(
   parameter int NUM_KEYS = 2,
   localparam int STG_W   = $clog2(NUM_KEYS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_wr,
   input  logic             key_hit,
   input  logic             prot_accept,
   output logic [STG_W-1:0] stage,
   output lock_st_t         status,
   output logic             open
);
   localparam logic [STG_W-1:0] STG_LAST = STG_W'(NUM_KEYS);
   logic [STG_W-1:0] stage_q, stage_d;

   always_comb begin
      stage_d = stage_q;
      if (prot_accept) begin
         stage_d = '0;
      end else if (lock_wr) begin
         if (stage_q != STG_LAST && key_hit) stage_d = stage_q + 1'b1;
         else                                stage_d = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= stage_d;
   end

   assign stage = stage_q;
   assign open  = (stage_q == STG_LAST);

   // the way progress maps onto the two status bits depends on the key count
   if (NUM_KEYS == 2) begin : g_st2
      always_comb begin
         unique case (stage_q)
            2'd0:    status = ST_LOCKED;
            2'd1:    status = 2'd1;
            default: status = ST_OPEN;
         endcase
      end
   end else begin : g_st3
      assign status = lock_st_t'(stage_q);
   end
endmodule

// File: rtl/prot_hold_reg.sv
module prot_hold_reg #(
   parameter int          DATA_W    = 32,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_wr,
   input  logic              open,
   input  logic [DATA_W-1:0] wr_data,
   output logic              prot_accept,
   output logic [DATA_W-1:0] prot_value,
   output logic              prot_we,
   output logic              viol
);
   assign prot_accept = prot_wr && open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_value <= RESET_VAL;
         prot_we    <= 1'b0;
         viol       <= 1'b0;
      end else begin
         prot_we <= prot_accept;
         if (prot_accept)        prot_value <= wr_data;
         if (prot_wr && !open)   viol       <= 1'b1;
      end
   end
endmodule

// File: rtl/unlock_read_mux.sv
module unlock_read_mux
   import keyed_unlock_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter logic [ADDR_W-1:0] LOCK_ADDR = '0,
   parameter logic [ADDR_W-1:0] DATA_ADDR = '0
) (
   input  logic [ADDR_W-1:0] rd_addr,
   input  lock_st_t          status,
   input  logic [DATA_W-1:0] prot_value,
   output logic [DATA_W-1:0] rd_data
);
   always_comb begin
      if (rd_addr == LOCK_ADDR)      rd_data = DATA_W'(status);
      else if (rd_addr == DATA_ADDR) rd_data = prot_value;
      else                           rd_data = '0;
   end
endmodule

// File: rtl/keyed_unlock_seq.sv
module keyed_unlock_seq
   import keyed_unlock_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int KEY_W     = 16,
   parameter int NUM_KEYS  = 2,
   parameter logic [MAX_KEYS*KEY_W-1:0] KEYS = {16'h0000, 16'hAAAA, 16'h5555},
   parameter logic [ADDR_W-1:0] LOCK_ADDR = 4'h0,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 4'h4,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        lock_status,
   output logic              prot_we,
   output logic [DATA_W-1:0] prot_value,
   output logic              viol
);
   localparam int STG_W = $clog2(NUM_KEYS + 1);

   if (NUM_KEYS < 2 || NUM_KEYS > MAX_KEYS) begin : g_bad_keys
      $error("NUM_KEYS must be 2 or 3");
   end
   if (KEY_W < 2 || KEY_W > DATA_W) begin : g_bad_keyw
      $error("KEY_W must lie between 2 and DATA_W");
   end
   if (LOCK_ADDR == DATA_ADDR) begin : g_bad_addr
      $error("LOCK_ADDR and DATA_ADDR must differ");
   end

   logic             lock_wr, prot_wr, key_hit, prot_accept, open;
   logic [STG_W-1:0] stage;
   lock_st_t         status;

   assign lock_wr = wr_en && (wr_addr == LOCK_ADDR);
   assign prot_wr = wr_en && (wr_addr == DATA_ADDR);

   unlock_key_match #(
      .DATA_W(DATA_W), .KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS), .KEYS(KEYS)
   ) u_match (
      .stage(stage), .wr_data(wr_data), .key_hit(key_hit)
   );

   unlock_stage_ctrl #(.NUM_KEYS(NUM_KEYS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr), .key_hit(key_hit),
      .prot_accept(prot_accept), .stage(stage), .status(status), .open(open)
   );

   prot_hold_reg #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) u_hold (
      .clk(clk), .rst_n(rst_n), .prot_wr(prot_wr), .open(open),
      .wr_data(wr_data), .prot_accept(prot_accept),
      .prot_value(prot_value), .prot_we(prot_we), .viol(viol)
   );

   unlock_read_mux #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .LOCK_ADDR(LOCK_ADDR), .DATA_ADDR(DATA_ADDR)
   ) u_rd (
      .rd_addr(rd_addr), .status(status), .prot_value(prot_value),
      .rd_data(rd_data)
   );

   assign lock_status = status;
endmodule

// File: rtl/keyed_unlock_seq_chk.sv
module keyed_unlock_seq_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter logic [ADDR_W-1:0] LOCK_ADDR = 4'h0,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 4'h4,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [1:0]        lock_status,
   input logic              prot_we,
   input logic [DATA_W-1:0] prot_value,
   input logic              viol
);
   p_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (lock_status == 2'd0 && !prot_we && !viol &&
                        prot_value == RESET_VAL));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(lock_status));

   p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      prot_we |=> !prot_we);

   p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_we) |-> ($past(lock_status) == 2'd3 && $past(wr_en) &&
                          $past(wr_addr) == DATA_ADDR && lock_status == 2'd0));

   p_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == DATA_ADDR && lock_status != 2'd3)
      |=> ($stable(prot_value) && !prot_we && viol));

   p_viol_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> viol);

   p_rd_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == LOCK_ADDR) |-> (rd_data == DATA_W'(lock_status)));

   p_relock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == LOCK_ADDR && lock_status == 2'd3)
      |=> lock_status == 2'd0);
endmodule

bind keyed_unlock_seq keyed_unlock_seq_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .LOCK_ADDR(LOCK_ADDR), .DATA_ADDR(DATA_ADDR), .RESET_VAL(RESET_VAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .rd_addr(rd_addr), .rd_data(rd_data), .lock_status(lock_status),
   .prot_we(prot_we), .prot_value(prot_value), .viol(viol)
);

// File: tb/keyed_unlock_seq_bench.sv
module keyed_unlock_seq_bench;
   localparam logic [3:0] A_LOCK = 4'h0;
   localparam logic [3:0] A_DATA = 4'h4;
   localparam logic [3:0] A_NONE = 4'h8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;

   logic [31:0] rd2, rd3, val2, val3;
   logic [1:0]  st2, st3;
   logic        we2, we3, vi2, vi3;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   keyed_unlock_seq u_keyed_unlock_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd2),
      .lock_status(st2), .prot_we(we2), .prot_value(val2), .viol(vi2)
   );

   keyed_unlock_seq #(
      .NUM_KEYS(3), .KEYS({16'hDDDD, 16'hCCCC, 16'h7777})
   ) u_keyed_unlock_seq_k3 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd3),
      .lock_status(st3), .prot_we(we3), .prot_value(val3), .viol(vi3)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one write, returns at the negedge after the capturing edge
   task automatic wr(logic [3:0] a, logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1", "status2", 32'(st2), 0);
      check("R1", "status3", 32'(st3), 0);
      check("R1", "value", val2, 0);
      check("R1", "we", 32'(we2), 0);
      check("R1", "viol", 32'(vi2), 0);
   endtask

   task automatic t_two_key();
      do_reset();
      rd_addr = A_LOCK;
      wr(A_LOCK, 32'h5555);
      check("R2", "status after key0", 32'(st2), 1);
      #1 check("R7", "lock read stage1", rd2, 32'h1);
      wr(A_LOCK, 32'hAAAA);
      check("R2", "status after key1", 32'(st2), 3);
      #1 check("R7", "lock read open", rd2, 32'h3);
      wr(A_DATA, 32'h1234ABCD);
      check("R5", "value", val2, 32'h1234ABCD);
      check("R5", "we pulse", 32'(we2), 1);
      check("R5", "relocked", 32'(st2), 0);
      @(negedge clk);
      check("R5", "we one cycle", 32'(we2), 0);
      rd_addr = A_DATA;
      #1 check("R7", "data read", rd2, 32'h1234ABCD);
      rd_addr = A_NONE;
      #1 check("R7", "unmapped read", rd2, 0);
      check("R6", "no viol on good write", 32'(vi2), 0);
   endtask

   task automatic t_three_key();
      do_reset();
      wr(A_LOCK, 32'h7777);
      check("R3", "stage1", 32'(st3), 1);
      wr(A_LOCK, 32'hCCCC);
      check("R3", "stage2", 32'(st3), 2);
      wr(A_LOCK, 32'hDDDD);
      check("R3", "stage3", 32'(st3), 3);
      wr(A_DATA, 32'h0000CAFE);
      check("R5", "k3 value", val3, 32'h0000CAFE);
      check("R5", "k3 relocked", 32'(st3), 0);
   endtask

   task automatic t_wrong_key();
      do_reset();
      wr(A_LOCK, 32'h5555);
      wr(A_LOCK, 32'h5555);
      check("R4", "repeated key0", 32'(st2), 0);
      wr(A_LOCK, 32'hAAAA);
      check("R4", "key1 first", 32'(st2), 0);
      wr(A_LOCK, 32'h00015555);
      check("R4", "high bits set", 32'(st2), 0);
      wr(A_LOCK, 32'h7777);
      wr(A_LOCK, 32'hDDDD);
      check("R4", "k3 skipped key", 32'(st3), 0);
      wr(A_LOCK, 32'h7777);
      wr(A_LOCK, 32'hCCCC);
      wr(A_LOCK, 32'hCCCC);
      check("R4", "k3 wrong last", 32'(st3), 0);
   endtask

   task automatic t_locked_write();
      do_reset();
      wr(A_DATA, 32'hDEADBEEF);
      check("R6", "value kept", val2, 0);
      check("R6", "no pulse", 32'(we2), 0);
      check("R6", "viol set", 32'(vi2), 1);
      wr(A_LOCK, 32'h5555);
      wr(A_DATA, 32'h11111111);
      check("R6", "partial value kept", val2, 0);
      check("R6", "partial status kept", 32'(st2), 1);
      wr(A_LOCK, 32'hAAAA);
      wr(A_DATA, 32'h00000055);
      check("R6", "later accept", val2, 32'h55);
      check("R6", "viol sticky", 32'(vi2), 1);
   endtask

   task automatic t_relock();
      do_reset();
      wr(A_LOCK, 32'h5555);
      wr(A_LOCK, 32'hAAAA);
      wr(A_LOCK, 32'h5555);
      check("R8", "relock on lock write", 32'(st2), 0);
      wr(A_DATA, 32'h99999999);
      check("R8", "write refused", val2, 0);
   endtask

   task automatic t_other_addr();
      do_reset();
      wr(A_LOCK, 32'h5555);
      wr(A_LOCK, 32'hAAAA);
      wr(A_NONE, 32'h5555);
      check("R9", "status kept", 32'(st2), 3);
      check("R9", "value kept", val2, 0);
      wr(A_DATA, 32'h00000077);
      check("R9", "still accepts", val2, 32'h77);
   endtask

   initial begin
      t_reset();
      t_two_key();
      t_three_key();
      t_wrong_key();
      t_locked_write();
      t_relock();
      t_other_addr();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule